// File: doc/BRIEF.md
# AC97 Link Frame Controller

This block is the controller end of an AC97 serial audio link. It runs from the codec's bit clock and counts positions within a 256-bit frame. From that count it drives the frame sync, shifts a 13-slot output frame onto the serial data line, and collects the codec's serial input. The output frame is one 16-bit tag slot followed by twelve 20-bit data slots. Each output frame carries an optional register command and one stereo playback sample. From every input frame the block rebuilds a stereo recording sample.

On the system side the audio path is eight bits wide. An 8-bit playback value is widened and sent on both the left and right channels. The incoming 20-bit left and right samples are averaged, and the top eight bits of the average are presented with a one-cycle ready strobe, once per frame. A cold-reset output holds the codec in reset while the block is in reset, and for a set number of bit clocks after that.

Top module: `ac97_link_ctrl`

## Requirements
- R1: After the codec reset output goes high, frames repeat every 256 bit clocks. The sync output is high for the first 16 bit clocks of each frame (the tag slot) and low for the remaining 240.
- R2: Each frame is sent MSB first, starting with the tag, with one bit per bit clock. The serial output changes only after a rising edge. Serial input bit k of a frame is sampled on the falling edge that falls inside frame position k.
- R3: The outgoing tag has bit 15 set (valid frame), bits 12 and 11 set (slots 3 and 4 valid), and bits 14 and 13 equal to the command flag that was latched for this frame. All other tag bits are zero.
- R4: When the command flag is latched, slot 1 carries {0, address[6:0], twelve zeros} and slot 2 carries {data[15:0], four zeros}. When the flag is not latched, both slots are zero. The command inputs are sampled on the rising edge that ends the last bit of the previous frame.
- R5: Slots 3 and 4 both carry {play[7:0], twelve zeros}. The play value is sampled on the same frame-boundary edge as the command inputs. Slots 5 to 12 are zero.
- R6: If the incoming frame is valid for recording (see R7), the ready output is high for exactly one bit clock, at frame position 96, which is the bit after slot 4 ends. At that time the record output equals bits [20:13] of the 21-bit signed sum of the incoming left sample (slot 3) and right sample (slot 4).
- R7: A frame is valid for recording only when incoming tag bits 12 and 11 are both set. Tag bit 15 is the first bit of the frame. In any other frame, ready stays low and the record output keeps its previous value.
- R8: The codec reset output is low while the block's reset is asserted, and for COLD_CYCLES bit clocks after reset is released. While it is low, sync and serial output stay low.
- R9: While reset is asserted, the record output and the ready output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock from the codec (12.288 MHz) |
| rstN | input | 1 | Asynchronous active-low reset |
| codecResetN | output | 1 | Active-low cold reset to the codec |
| syncOut | output | 1 | Frame sync, high during the tag slot |
| sdataOut | output | 1 | Serial frame data to the codec |
| sdataIn | input | 1 | Serial frame data from the codec |
| playSample | input | 8 | Playback value, sent on both channels |
| cmdValid | input | 1 | Request a register command in the next frame |
| cmdAddr | input | 7 | Command register address |
| cmdData | input | 16 | Command register data |
| recSample | output | 8 | Reduced recording sample |
| sampleReady | output | 1 | One-cycle strobe when recSample is updated |

## Verification
The bench builds the block with its default parameters: a 256-bit frame, a 16-bit tag, 20-bit slots, an 8-bit stored sample and a 16-cycle cold reset. Because these match the real link, every frame position the bench checks is the one seen in service. With the short cold reset, the bench can run about 260 back-to-back frames. Across those frames the playback value steps through all 256 codes. Commands appear and disappear on a fixed rhythm. The incoming tag is varied so that some frames are not valid for recording. The recording pairs include the extreme positive, extreme negative and mixed-sign values, so the averaging is tested at both rails and at the point where the sign flips.

// File: rtl/ac97_link_pkg.sv
package ac97_link_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic running;    // link active, frames in progress
    logic loadFrame;  // latch next frame's outgoing content
    logic grabTag;    // incoming tag slot complete
    logic grabLeft;   // incoming slot 3 complete
    logic grabRight;  // incoming slot 4 complete
  } linkStrobe_t;

endpackage

// File: rtl/ac97_link_ctl.sv
module ac97_link_ctl
  import ac97_link_pkg::*;
#(
  parameter int FRAME_BITS  = 256,
  parameter int TAG_BITS    = 16,
  parameter int SLOT_BITS   = 20,
  parameter int COLD_CYCLES = 16,
  parameter int POS_W       = 8
) (
  input  logic             bitClk,
  input  logic             rstN,
  output logic [POS_W-1:0] bitPos,
  output logic             syncOut,
  output logic             codecResetN,
  output linkStrobe_t      strobe
);

  localparam int HOLD_W = $clog2(COLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_DONE = HOLD_W'(COLD_CYCLES);
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] TAG_END   = POS_W'(TAG_BITS - 1);
  localparam logic [POS_W-1:0] LEFT_END  = POS_W'(TAG_BITS + 3 * SLOT_BITS - 1);
  localparam logic [POS_W-1:0] RIGHT_END = POS_W'(TAG_BITS + 4 * SLOT_BITS - 1);
  localparam logic [POS_W-1:0] TAG_LEN   = POS_W'(TAG_BITS);

  logic [HOLD_W-1:0] holdCnt;
  logic running;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (holdCnt != HOLD_DONE) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign running     = (holdCnt == HOLD_DONE);
  assign codecResetN = running;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      bitPos <= '0;
    end else if (!running || bitPos == LAST_POS) begin
      bitPos <= '0;
    end else begin
      bitPos <= bitPos + 1'b1;
    end
  end

  assign syncOut = running && (bitPos < TAG_LEN);

  always_comb begin
    strobe.running   = running;
    strobe.loadFrame = !running || (bitPos == LAST_POS);
    strobe.grabTag   = running && (bitPos == TAG_END);
    strobe.grabLeft  = running && (bitPos == LEFT_END);
    strobe.grabRight = running && (bitPos == RIGHT_END);
  end

endmodule

// File: rtl/ac97_link_dp.sv
module ac97_link_dp
  import ac97_link_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int STORE_W    = 8,
  parameter int CMD_ADDR_W = 7,
  parameter int CMD_DATA_W = 16,
  parameter int POS_W      = 8
) (
  input  logic                  bitClk,
  input  logic                  rstN,
  input  linkStrobe_t           strobe,
  input  logic [POS_W-1:0]      bitPos,
  input  logic                  sdataIn,
  output logic                  sdataOut,
  input  logic [STORE_W-1:0]    playSample,
  input  logic                  cmdValid,
  input  logic [CMD_ADDR_W-1:0] cmdAddr,
  input  logic [CMD_DATA_W-1:0] cmdData,
  output logic [STORE_W-1:0]    recSample,
  output logic                  sampleReady
);

  localparam int S1_MSB = FRAME_BITS - 1 - TAG_BITS;
  localparam int S2_MSB = S1_MSB - SLOT_BITS;
  localparam int S3_MSB = S2_MSB - SLOT_BITS;
  localparam int S4_MSB = S3_MSB - SLOT_BITS;
  localparam int LEFT_OK  = TAG_BITS - 4;
  localparam int RIGHT_OK = TAG_BITS - 5;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  // Outgoing frame content, latched at the frame boundary
  logic [STORE_W-1:0]    playLat;
  logic                  cmdLat;
  logic [CMD_ADDR_W-1:0] addrLat;
  logic [CMD_DATA_W-1:0] dataLat;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      playLat <= '0;
      cmdLat  <= 1'b0;
      addrLat <= '0;
      dataLat <= '0;
    end else if (strobe.loadFrame) begin
      playLat <= playSample;
      cmdLat  <= cmdValid;
      addrLat <= cmdAddr;
      dataLat <= cmdData;
    end
  end

  logic [TAG_BITS-1:0]   tagWord;
  logic [SLOT_BITS-1:0]  cmdAddrSlot, cmdDataSlot, pcmSlot;
  logic [FRAME_BITS-1:0] frameWord;

  always_comb begin
    tagWord = '0;
    tagWord[TAG_BITS-1] = 1'b1;
    tagWord[TAG_BITS-2] = cmdLat;
    tagWord[TAG_BITS-3] = cmdLat;
    tagWord[LEFT_OK]    = 1'b1;
    tagWord[RIGHT_OK]   = 1'b1;
    cmdAddrSlot = cmdLat ? (SLOT_BITS'(addrLat) << (SLOT_BITS - 1 - CMD_ADDR_W)) : '0;
    cmdDataSlot = cmdLat ? (SLOT_BITS'(dataLat) << (SLOT_BITS - CMD_DATA_W)) : '0;
    pcmSlot     = SLOT_BITS'(playLat) << (SLOT_BITS - STORE_W);
    frameWord = '0;
    frameWord[FRAME_BITS-1 -: TAG_BITS] = tagWord;
    frameWord[S1_MSB -: SLOT_BITS] = cmdAddrSlot;
    frameWord[S2_MSB -: SLOT_BITS] = cmdDataSlot;
    frameWord[S3_MSB -: SLOT_BITS] = pcmSlot;
    frameWord[S4_MSB -: SLOT_BITS] = pcmSlot;
  end

  assign sdataOut = strobe.running ? frameWord[LAST_POS - bitPos] : 1'b0;

  // Incoming path: sample on falling edge, shift on rising edge
  logic inBitNeg;
  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) inBitNeg <= 1'b0;
    else       inBitNeg <= sdataIn;
  end

  logic [SLOT_BITS-2:0] inShift;
  logic [SLOT_BITS-1:0] slotWord;
  assign slotWord = {inShift, inBitNeg};

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)               inShift <= '0;
    else if (strobe.running) inShift <= slotWord[SLOT_BITS-2:0];
  end

  logic [TAG_BITS-1:0]  inTag;
  logic [SLOT_BITS-1:0] leftHold;
  logic signed [SLOT_BITS:0] sumLR;

  assign sumLR = $signed({leftHold[SLOT_BITS-1], leftHold}) +
                 $signed({slotWord[SLOT_BITS-1], slotWord});

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      inTag       <= '0;
      leftHold    <= '0;
      recSample   <= '0;
      sampleReady <= 1'b0;
    end else begin
      sampleReady <= 1'b0;
      if (strobe.grabTag)  inTag    <= slotWord[TAG_BITS-1:0];
      if (strobe.grabLeft) leftHold <= slotWord;
      if (strobe.grabRight && inTag[LEFT_OK] && inTag[RIGHT_OK]) begin
        recSample   <= sumLR[SLOT_BITS -: STORE_W];
        sampleReady <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ac97_link_ctrl.sv
module ac97_link_ctrl
  import ac97_link_pkg::*;
#(
  parameter int FRAME_BITS  = 256,
  parameter int TAG_BITS    = 16,
  parameter int SLOT_BITS   = 20,
  parameter int STORE_W     = 8,
  parameter int CMD_ADDR_W  = 7,
  parameter int CMD_DATA_W  = 16,
  parameter int COLD_CYCLES = 16
) (
  input  logic                  bitClk,
  input  logic                  rstN,
  output logic                  codecResetN,
  output logic                  syncOut,
  output logic                  sdataOut,
  input  logic                  sdataIn,
  input  logic [STORE_W-1:0]    playSample,
  input  logic                  cmdValid,
  input  logic [CMD_ADDR_W-1:0] cmdAddr,
  input  logic [CMD_DATA_W-1:0] cmdData,
  output logic [STORE_W-1:0]    recSample,
  output logic                  sampleReady
);

  localparam int POS_W = $clog2(FRAME_BITS);

  linkStrobe_t      strobe;
  logic [POS_W-1:0] bitPos;

  ac97_link_ctl #(
    .FRAME_BITS(FRAME_BITS), .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS),
    .COLD_CYCLES(COLD_CYCLES), .POS_W(POS_W)
  ) ctl_i (
    .bitClk(bitClk), .rstN(rstN), .bitPos(bitPos), .syncOut(syncOut),
    .codecResetN(codecResetN), .strobe(strobe)
  );

  ac97_link_dp #(
    .FRAME_BITS(FRAME_BITS), .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS),
    .STORE_W(STORE_W), .CMD_ADDR_W(CMD_ADDR_W), .CMD_DATA_W(CMD_DATA_W),
    .POS_W(POS_W)
  ) dp_i (
    .bitClk(bitClk), .rstN(rstN), .strobe(strobe), .bitPos(bitPos),
    .sdataIn(sdataIn), .sdataOut(sdataOut), .playSample(playSample),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .recSample(recSample), .sampleReady(sampleReady)
  );

endmodule

// File: rtl/ac97_link_chk.sv
module ac97_link_chk #(
  parameter int FRAME_BITS = 256,
  parameter int TAG_BITS   = 16,
  parameter int STORE_W    = 8
) (
  input logic               bitClk,
  input logic               rstN,
  input logic               codecResetN,
  input logic               syncOut,
  input logic               sdataOut,
  input logic [STORE_W-1:0] recSample,
  input logic               sampleReady
);

  localparam int RUN_W = $clog2(FRAME_BITS) + 1;

  logic [RUN_W-1:0] highRun, lowRun;
  logic seenFall;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      highRun  <= '0;
      lowRun   <= '0;
      seenFall <= 1'b0;
    end else begin
      highRun <= syncOut ? highRun + 1'b1 : '0;
      lowRun  <= syncOut ? '0 : lowRun + 1'b1;
      if (!syncOut && highRun != '0) seenFall <= 1'b1;
    end
  end

  // R8
  cold_quiet_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    !codecResetN |-> (!syncOut && !sdataOut));

  // R1
  sync_high_len_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    $fell(syncOut) |-> (highRun == RUN_W'(TAG_BITS)));

  // R1
  sync_low_len_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    ($rose(syncOut) && seenFall) |-> (lowRun == RUN_W'(FRAME_BITS - TAG_BITS)));

  // R6
  ready_single_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    sampleReady |=> !sampleReady);

  // R7
  rec_hold_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    !sampleReady |-> $stable(recSample));

endmodule

bind ac97_link_ctrl ac97_link_chk #(
  .FRAME_BITS(FRAME_BITS), .TAG_BITS(TAG_BITS), .STORE_W(STORE_W)
) chk_i (
  .bitClk(bitClk), .rstN(rstN), .codecResetN(codecResetN),
  .syncOut(syncOut), .sdataOut(sdataOut), .recSample(recSample),
  .sampleReady(sampleReady)
);

// File: tb/ac97_link_ctrl_tb.sv
module ac97_link_ctrl_tb_top;

  logic bitClk = 1'b0;
  logic rstN = 1'b0;
  logic sdataIn = 1'b0;
  logic [7:0] playSample = '0;
  logic cmdValid = 1'b0;
  logic [6:0] cmdAddr = '0;
  logic [15:0] cmdData = '0;
  logic codecResetN, syncOut, sdataOut, sampleReady;
  logic [7:0] recSample;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  ac97_link_ctrl dut_i (
    .bitClk(bitClk), .rstN(rstN), .codecResetN(codecResetN),
    .syncOut(syncOut), .sdataOut(sdataOut), .sdataIn(sdataIn),
    .playSample(playSample), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .recSample(recSample), .sampleReady(sampleReady)
  );

  always #5 bitClk = ~bitClk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [255:0] gotOut;
  int syncErr, rdyCnt, rdyPos;
  logic [7:0] rdyVal;

  // Entry and exit: just after the rising edge that starts a frame
  task automatic runFrame(input logic [255:0] inF);
    syncErr = 0; rdyCnt = 0; rdyPos = -1;
    for (int k = 0; k < 256; k++) begin
      sdataIn = inF[255-k];
      @(negedge bitClk);
      gotOut[255-k] = sdataOut;
      if (syncOut != (k < 16)) syncErr++;
      if (sampleReady) begin rdyCnt++; rdyPos = k; rdyVal = recSample; end
      @(posedge bitClk); #1;
    end
  endtask

  function automatic logic [19:0] pickL(input int i);
    case (i)
      0: pickL = 20'h7FFFF;
      1: pickL = 20'h80000;
      2: pickL = 20'h7FFFF;
      3: pickL = 20'h00000;
      default: pickL = 20'((i * 32'h1F3D5) ^ 32'h3A5C1);
    endcase
  endfunction

  function automatic logic [19:0] pickR(input int i);
    case (i)
      0: pickR = 20'h7FFFF;
      1: pickR = 20'h80000;
      2: pickR = 20'h80000;
      3: pickR = 20'h00001;
      default: pickR = 20'((i * 32'h2A2B7) ^ 32'h55555);
    endcase
  endfunction

  initial begin
    #(10 * 200000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] curPlay, lastRec;
    logic curCv;
    logic [6:0] curAddr;
    logic [15:0] curData;
    int cold;

    // R9 / R8: reset state
    repeat (3) @(posedge bitClk);
    @(negedge bitClk);
    check(codecResetN == 1'b0, "R8", "codec reset in reset", codecResetN, 0);
    check(syncOut == 1'b0 && sdataOut == 1'b0, "R8", "sync/data in reset",
          {syncOut, sdataOut}, 0);
    check(recSample == 8'h00, "R9", "recSample in reset", recSample, 0);
    check(sampleReady == 1'b0, "R9", "ready in reset", sampleReady, 0);

    @(posedge bitClk); #1;
    rstN = 1'b1;
    cold = 0;
    do begin
      @(posedge bitClk); #1;
      cold++;
      if (!codecResetN)
        check(syncOut == 1'b0, "R8", "sync during cold hold", syncOut, 0);
    end while (!codecResetN && cold < 1000);
    check(cold == 16, "R8", "cold reset length", cold, 16);

    curPlay = 8'h00; curCv = 1'b0; curAddr = '0; curData = '0;
    lastRec = 8'h00;

    for (int i = 0; i < 260; i++) begin
      logic [255:0] inF;
      logic [15:0] inTag;
      logic [15:0] expTag;
      logic [19:0] l, r;
      logic [19:0] e1, e2, ePcm;
      int sumI, expRec;
      bit validRec;

      // Next frame's outgoing content, sampled at this frame's end
      playSample = 8'(i);
      cmdValid   = (i % 5 == 2);
      cmdAddr    = 7'((i * 13) & 8'h7F);
      cmdData    = 16'((i * 32'h9E37) & 32'hFFFF);

      inTag = (i % 7 == 3) ? 16'h9000 : ((i % 7 == 5) ? 16'h8800 : 16'h9800);
      l = pickL(i); r = pickR(i);
      inF = '0;
      inF[255:240] = inTag;
      inF[199:180] = l;
      inF[179:160] = r;

      runFrame(inF);

      // R1: sync pattern
      check(syncErr == 0, "R1", "sync pattern errors", syncErr, 0);

      // R2 / R3: tag sent first, MSB first
      expTag = {1'b1, curCv, curCv, 1'b1, 1'b1, 11'b0};
      check(gotOut[255:240] == expTag, "R3", "outgoing tag",
            gotOut[255:240], expTag);

      // R4: command slots
      e1 = curCv ? {1'b0, curAddr, 12'b0} : 20'h0;
      e2 = curCv ? {curData, 4'b0} : 20'h0;
      check(gotOut[239:220] == e1 && gotOut[219:200] == e2, "R4",
            "command slots", {gotOut[239:220], gotOut[219:200]}, {e1, e2});

      // R5: PCM slots and empty slots
      ePcm = {curPlay, 12'b0};
      check(gotOut[199:180] == ePcm && gotOut[179:160] == ePcm, "R5",
            "pcm slots", {gotOut[199:180], gotOut[179:160]}, {ePcm, ePcm});
      check(gotOut[159:0] == '0, "R5", "slots 5-12 empty",
            64'(gotOut[159:0] != '0), 0);

      // R6 / R7 / R2: recording
      validRec = inTag[12] && inTag[11];
      sumI = int'($signed(l)) + int'($signed(r));
      expRec = (sumI >>> 13) & 255;
      if (validRec) begin
        check(rdyCnt == 1 && rdyPos == 96, "R6", "ready count/position",
              {rdyCnt[31:0], rdyPos[31:0]}, {32'd1, 32'd96});
        check(rdyVal == 8'(expRec), "R6", "recorded value", rdyVal, expRec);
        lastRec = 8'(expRec);
      end else begin
        check(rdyCnt == 0, "R7", "no ready on invalid tag", rdyCnt, 0);
      end
      check(recSample == lastRec, "R7", "record output held", recSample, lastRec);

      curPlay = playSample; curCv = cmdValid;
      curAddr = cmdAddr; curData = cmdData;
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule